// File: doc/BRIEF.md
# Periodic Timer Bank

This block holds eight independent 32-bit down-counters behind a small register bus. Each channel has a reload value, a live count, a control word and a sticky expiry flag. While a channel is enabled it counts down by one each clock. When it would pass zero it reloads from its reload value, raises its flag and runs on. Software asks for an event every N clocks by writing N-1 as the reload value.

Each channel drives its own interrupt line, and an OR of all eight lines is also provided. A channel can be cascaded onto the channel numbered one below it, so that it counts only on the cycles when that lower channel expires. This builds counters wider than 32 bits.

A bank-wide control word can freeze every channel at once. Bus access takes one cycle. Writes take effect at the clock edge on which `bus_wr` is high. Read data is a combinational function of `bus_addr` and the current register state. All pins are plain control and status signals. No part of the interface carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `period_timer_bank`

## Requirements
- R1: After reset every register reads 0, every channel is stopped, and `irq_ch` and `irq_any` are 0.
- R2: The bank control word is at byte address 0x000. Channel n (0 to 7) occupies 0x100 + 16*n, with reload value at +0x0, live count at +0x4, control at +0x8 and flag at +0xC. Any other address reads 0, and writes to it are dropped.
- R3: An enabled channel decrements its count by one each clock, and the live count register returns the current value.
- R4: When an enabled channel's count is 0, the next counting step reloads the reload value and sets flag bit 0. The expiry period is therefore the reload value plus one clocks.
- R5: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves the flag unchanged.
- R6: If an expiry and a flag-clear write occur in the same cycle, the flag stays set.
- R7: `irq_ch[n]` is high exactly while channel n's flag is 1 and its control bit 1 (interrupt enable) is 1. `irq_any` is the OR of all `irq_ch` bits.
- R8: Clearing control bit 0 (enable) freezes the count. A write that changes enable from 0 to 1 restarts the count from the reload value.
- R9: With control bit 2 (cascade) set, channel n for n >= 1 counts only in cycles in which channel n-1 expires. Channel 0 ignores bit 2.
- R10: While bit 1 of the bank control word is 1, no channel counts or expires. Bit 1 reads back as written, and every other bit of the bank control word reads 0.
- R11: Writes to a live count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, acted on at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_ch | output | 8 | Per-channel interrupt lines |
| irq_any | output | 1 | OR of all channel interrupt lines |

## Verification
On every cycle, the assertions inside each channel check the following step-wise behaviour. Each counting step decrements the count. Each expiry is followed by a reload and a set flag. A channel holds still while it is disabled, frozen, or cascaded and waiting on its lower neighbour. The flag never drops unless a clear write arrives.

Only the bench's scenarios can show the properties that need a whole sequence. These are the exact expiry period as seen from the bus, the restart of the count from the reload value, the address map, the outcome of an expiry colliding with a clear, and the interrupt gating. They also include the combined period of a cascaded pair.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  typedef struct packed {
    logic chain;
    logic ie;
    logic en;
  } ctrl_t;

  localparam logic [1:0] SEL_RELOAD = 2'd0;
  localparam logic [1:0] SEL_COUNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL   = 2'd2;
  localparam logic [1:0] SEL_FLAG   = 2'd3;

  localparam int unsigned CH_BASE      = 'h100;
  localparam int unsigned CH_SPAN_LOG2 = 4;

endpackage

// File: rtl/ptb_decode.sv
module ptb_decode
  import ptb_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned CIW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  output logic              hit_bank,
  output logic              hit_ch,
  output logic [CIW-1:0]    ch_idx,
  output logic [1:0]        reg_sel,
  output logic              wr_bank,
  output logic [NUM_CH-1:0] wr_reload,
  output logic [NUM_CH-1:0] wr_ctrl,
  output logic [NUM_CH-1:0] wr_flag
);

  localparam int unsigned IW = AW - CH_SPAN_LOG2;
  localparam logic [AW-1:0] BASE_V  = AW'(CH_BASE);
  localparam logic [IW-1:0] LIMIT_V = IW'(NUM_CH);

  logic [AW-1:0] ofs;

  always_comb begin
    ofs      = addr - BASE_V;
    hit_bank = (addr == '0);
    hit_ch   = (addr >= BASE_V) && (ofs[AW-1:CH_SPAN_LOG2] < LIMIT_V)
               && (addr[1:0] == 2'b00);
    ch_idx   = ofs[CH_SPAN_LOG2 +: CIW];
    reg_sel  = addr[3:2];
    wr_bank  = wr && hit_bank;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_strobe
    logic mine;
    assign mine         = wr && hit_ch && (ch_idx == CIW'(n));
    assign wr_reload[n] = mine && (reg_sel == SEL_RELOAD);
    assign wr_ctrl[n]   = mine && (reg_sel == SEL_CTRL);
    assign wr_flag[n]   = mine && (reg_sel == SEL_FLAG);
  end

endmodule

// File: rtl/ptb_channel.sv
module ptb_channel
  import ptb_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter bit          IS_FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          wr_reload,
  input  logic          wr_ctrl,
  input  logic          wr_flag,
  input  logic [DW-1:0] wdata,
  input  logic          lower_expire,
  output logic [DW-1:0] reload_q,
  output logic [DW-1:0] count_q,
  output ctrl_t         ctrl_q,
  output logic          flag_q,
  output logic          expire,
  output logic          irq
);

  logic  start;
  logic  step;
  logic  run;
  logic  clr_req;
  ctrl_t ctrl_new;

  always_comb begin
    ctrl_new = ctrl_t'(wdata[2:0]);
    start    = wr_ctrl && ctrl_new.en && !ctrl_q.en;
    step     = (!IS_FIRST && ctrl_q.chain) ? lower_expire : 1'b1;
    run      = ctrl_q.en && !halt && step;
    expire   = run && (count_q == '0);
    clr_req  = wr_flag && wdata[0];
    irq      = flag_q && ctrl_q.ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_ctrl)   ctrl_q   <= ctrl_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (start) begin
      count_q <= reload_q;
    end else if (run) begin
      count_q <= expire ? reload_q : count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (expire)  flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count_q != '0) |=> count_q == $past(count_q) - 1'b1); // R3

  AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count_q == $past(reload_q)) && flag_q); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q); // R5

  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && clr_req) |=> flag_q); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !start) |=> $stable(count_q)); // R8

  AST_CASCADE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_FIRST && ctrl_q.chain && !lower_expire && !start)
      |=> $stable(count_q)); // R9

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !start) |=> $stable(count_q)); // R10

endmodule

// File: rtl/period_timer_bank.sv
module period_timer_bank
  import ptb_pkg::*;
#(
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] irq_ch,
  output logic              irq_any
);

  localparam int unsigned CIW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              hit_bank;
  logic              hit_ch;
  logic [CIW-1:0]    ch_idx;
  logic [1:0]        reg_sel;
  logic              wr_bank;
  logic [NUM_CH-1:0] wr_reload;
  logic [NUM_CH-1:0] wr_ctrl;
  logic [NUM_CH-1:0] wr_flag;
  logic [NUM_CH-1:0] expire;
  logic [NUM_CH-1:0] flag_q;
  logic [DW-1:0]     reload_q [NUM_CH];
  logic [DW-1:0]     count_q  [NUM_CH];
  ctrl_t             ctrl_q   [NUM_CH];
  logic              halt_q;

  ptb_decode #(.AW(AW), .NUM_CH(NUM_CH)) u_decode (
    .addr      (bus_addr),
    .wr        (bus_wr),
    .hit_bank  (hit_bank),
    .hit_ch    (hit_ch),
    .ch_idx    (ch_idx),
    .reg_sel   (reg_sel),
    .wr_bank   (wr_bank),
    .wr_reload (wr_reload),
    .wr_ctrl   (wr_ctrl),
    .wr_flag   (wr_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       halt_q <= 1'b0;
    else if (wr_bank) halt_q <= bus_wdata[1];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic lower;
    if (n == 0) begin : g_first
      assign lower = 1'b0;
    end else begin : g_rest
      assign lower = expire[n-1];
    end

    ptb_channel #(.DW(DW), .IS_FIRST(n == 0)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt         (halt_q),
      .wr_reload    (wr_reload[n]),
      .wr_ctrl      (wr_ctrl[n]),
      .wr_flag      (wr_flag[n]),
      .wdata        (bus_wdata),
      .lower_expire (lower),
      .reload_q     (reload_q[n]),
      .count_q      (count_q[n]),
      .ctrl_q       (ctrl_q[n]),
      .flag_q       (flag_q[n]),
      .expire       (expire[n]),
      .irq          (irq_ch[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_bank) begin
      bus_rdata[1] = halt_q;
    end else if (hit_ch) begin
      unique case (reg_sel)
        SEL_RELOAD: bus_rdata = reload_q[ch_idx];
        SEL_COUNT:  bus_rdata = count_q[ch_idx];
        SEL_CTRL:   bus_rdata = {{(DW-3){1'b0}}, ctrl_q[ch_idx]};
        SEL_FLAG:   bus_rdata = {{(DW-1){1'b0}}, flag_q[ch_idx]};
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_any = |irq_ch;

  AST_ANY_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (flag_q != '0)); // R7

endmodule

// File: tb/test_period_timer_bank.sv
`timescale 1ns/100ps
module test_period_timer_bank;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    {OP_WR,   12'h100, 32'd9,    32'd0, 4'd3},  // channel 0 reload 9
    {OP_WR,   12'h108, 32'd3,    32'd0, 4'd3},  // enable + irq enable
    {OP_RD,   12'h104, 32'd0,    32'd9, 4'd3},  // R3 starts at reload
    {OP_IDLE, 12'h000, 32'd4,    32'd0, 4'd3},
    {OP_RD,   12'h104, 32'd0,    32'd5, 4'd3},  // R3 four steps down
    {OP_IDLE, 12'h000, 32'd5,    32'd0, 4'd4},
    {OP_RD,   12'h10C, 32'd0,    32'd0, 4'd4},  // R4 at zero, not yet flagged
    {OP_IDLE, 12'h000, 32'd1,    32'd0, 4'd4},
    {OP_RD,   12'h10C, 32'd0,    32'd1, 4'd4},  // R4 flag after load+1 clocks
    {OP_RD,   12'h104, 32'd0,    32'd9, 4'd4},  // R4 reloaded
    {OP_WR,   12'h10C, 32'd0,    32'd0, 4'd5},
    {OP_RD,   12'h10C, 32'd0,    32'd1, 4'd5},  // R5 zero write keeps flag
    {OP_WR,   12'h10C, 32'd1,    32'd0, 4'd5},
    {OP_RD,   12'h10C, 32'd0,    32'd0, 4'd5},  // R5 one write clears
    {OP_RD,   12'h104, 32'd0,    32'd7, 4'd3},  // R3 still running
    {OP_WR,   12'h108, 32'd0,    32'd0, 4'd8},  // disable
    {OP_IDLE, 12'h000, 32'd3,    32'd0, 4'd8},
    {OP_RD,   12'h104, 32'd0,    32'd6, 4'd8},  // R8 frozen
    {OP_WR,   12'h104, 32'h55,   32'd0, 4'd11},
    {OP_RD,   12'h104, 32'd0,    32'd6, 4'd11}, // R11 count not writable
    {OP_RD,   12'h100, 32'd0,    32'd9, 4'd2},  // R2 reload readback
    {OP_WR,   12'h0F0, 32'hFF,   32'd0, 4'd2},
    {OP_RD,   12'h0F0, 32'd0,    32'd0, 4'd2}   // R2 hole reads zero
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_ch;
  logic        irq_any;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  period_timer_bank i_period_timer_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ch(irq_ch),
    .irq_any(irq_any)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input int req, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1ms;
    total++; bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    rd(12'h000, 1, 32'd0);
    rd(12'h104, 1, 32'd0);
    rd(12'h178, 1, 32'd0);
    check(1, {23'd0, irq_any, irq_ch}, 32'd0);
    rst_n = 1'b1;
    idle(1);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR:   wr(TBL[i].addr, TBL[i].data);
        OP_RD:   rd(TBL[i].addr, int'(TBL[i].req), TBL[i].exp);
        default: idle(int'(TBL[i].data));
      endcase
    end

    // R7 interrupt gating on channel 2
    wr(12'h120, 32'd20);
    wr(12'h128, 32'd1);
    idle(21);
    rd(12'h12C, 7, 32'd1);
    check(7, {23'd0, irq_any, irq_ch}, 32'd0);
    wr(12'h128, 32'd2);
    check(7, {23'd0, irq_any, irq_ch}, 32'h104);
    wr(12'h12C, 32'd1);
    check(7, {23'd0, irq_any, irq_ch}, 32'd0);

    // R6 expiry collides with clear on channel 1
    wr(12'h110, 32'd4);
    wr(12'h118, 32'd1);
    idle(5);
    rd(12'h11C, 4, 32'd1);
    idle(4);
    rd(12'h114, 3, 32'd0);
    wr(12'h11C, 32'd1);
    rd(12'h11C, 6, 32'd1);
    rd(12'h114, 4, 32'd4);
    wr(12'h118, 32'd0);

    // R9 cascade: channel 4 on channel 3
    wr(12'h130, 32'd2);
    wr(12'h140, 32'd1);
    wr(12'h148, 32'd5);
    wr(12'h138, 32'd1);
    rd(12'h144, 9, 32'd1);
    idle(2);
    rd(12'h144, 9, 32'd1);
    idle(3);
    rd(12'h144, 9, 32'd0);
    rd(12'h14C, 9, 32'd0);
    idle(1);
    rd(12'h14C, 9, 32'd1);
    rd(12'h144, 9, 32'd1);
    wr(12'h138, 32'd0);
    wr(12'h148, 32'd0);
    // R9 channel 0 ignores cascade bit
    wr(12'h100, 32'd3);
    wr(12'h108, 32'd5);
    idle(2);
    rd(12'h104, 9, 32'd1);
    wr(12'h108, 32'd0);

    // R10 bank freeze on channel 5
    wr(12'h150, 32'd100);
    wr(12'h158, 32'd1);
    idle(2);
    wr(12'h000, 32'd2);
    idle(5);
    rd(12'h154, 10, 32'd97);
    rd(12'h000, 10, 32'd2);
    wr(12'h000, 32'd0);
    rd(12'h154, 10, 32'd97);
    idle(1);
    rd(12'h154, 10, 32'd96);
    wr(12'h158, 32'd0);

    // R8 re-enable restarts from new reload
    wr(12'h100, 32'd40);
    wr(12'h108, 32'd1);
    rd(12'h104, 8, 32'd40);

    // R2 last channel decode
    wr(12'h170, 32'hDEADBEEF);
    rd(12'h170, 2, 32'hDEADBEEF);
    rd(12'h160, 2, 32'd0);

    // R7 combined line from channel 1 flag
    wr(12'h118, 32'd2);
    check(7, {23'd0, irq_any, irq_ch}, 32'h102);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule